// File: doc/BRIEF.md
# Read-Priority Data Bus Direction Arbiter

This block decides, cycle by cycle, whether a shared bidirectional data bus carries reads or writes. It sees only two facts from the outside: whether any read is waiting, and how many entries the write buffer currently holds. Reads are the default traffic. Writes pile up in the buffer and are drained in bursts. The bus turns to writes once the buffer reaches a high water mark, and it turns back once the buffer has drained down to a low water mark. The gap between the two marks limits how often the bus changes direction.

Every change of direction is followed by a fixed dead time, counted in clock cycles. During the dead time neither side is granted, so the bus drivers can hand over cleanly. A build-time option lets the arbiter drain writes early while no read is waiting. When a read then arrives, the arbiter gives up that early drain, unless the buffer has already reached the high mark. Choosing individual requests and storing the queues are left to other blocks.

Top module: `rw_bus_arbiter`

## Requirements
- R1: After reset the bus faces reads (`bus_is_write` = 0), `turn_busy` = 0, and both grants are 0.
- R2: While the bus faces reads and is not turning, `rd_grant` equals `rd_pending`. With early drain disabled, an occupancy below `HI_MARK` never turns the bus, however long reads stay idle.
- R3: When the bus faces reads, is not turning and `wr_level >= HI_MARK` is sampled at a clock edge, `bus_is_write` is 1 after that edge.
- R4: While the bus faces writes and `wr_level > LO_MARK`, it stays in write direction. When `wr_level <= LO_MARK` is sampled at an edge with no turnaround in progress, `bus_is_write` is 0 after that edge.
- R5: Each direction change starts a turnaround during which `turn_busy` = 1 for exactly `GAP_CYC` cycles. In that time both grants are 0.
- R6: `wr_grant` is 1 only when the bus faces writes, is not turning, and `wr_level` is nonzero.
- R7: `rd_grant` and `wr_grant` are never 1 in the same cycle.
- R8: Occupancy is not evaluated during a turnaround. The first decision on the new direction is taken at the first edge at which `turn_busy` is 0.
- R9: With `OPP_DRAIN` = 1, the bus turns to writes when no read is pending and `wr_level > LO_MARK`. Such an early drain returns to reads as soon as a read is pending while `wr_level < HI_MARK`.
- R10: With `OPP_DRAIN` = 1, a drain that has reached `HI_MARK` is not abandoned for a pending read. It continues until `wr_level <= LO_MARK`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_pending | input | 1 | At least one read is waiting |
| wr_level | input | OCC_W | Current write-buffer occupancy |
| bus_is_write | output | 1 | 1 = bus faces writes, 0 = reads |
| rd_grant | output | 1 | A read may use the bus this cycle |
| wr_grant | output | 1 | A write may use the bus this cycle |
| turn_busy | output | 1 | Direction turnaround in progress |

## Verification
A direction decision is registered, so a mark crossing that is sampled at an edge shows up on `bus_is_write` and `turn_busy` right after that same edge. The grants are combinational from the registered state, and they return exactly `GAP_CYC` edges later. The bench drives inputs and samples outputs on the falling edge. It steps one rising edge per sample and counts every register on the way. Each turnaround is therefore checked at each of its busy samples and at the first idle sample after it.

// File: rtl/rw_arb_pkg.sv
package rw_arb_pkg;
   typedef enum logic {
      BUS_RD = 1'b0,
      BUS_WR = 1'b1
   } bus_dir_e;
endpackage

// File: rtl/rw_gap_timer.sv
// Dead-time down-counter; loaded on every direction change.
module rw_gap_timer #(
   parameter int GAP_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (GAP_CYC == 0) begin : g_no_gap
         assign busy = 1'b0;
         logic unused_start;
         assign unused_start = start;
      end else begin : g_gap
         localparam int CW = $clog2(GAP_CYC + 1);
         localparam logic [CW-1:0] LOAD = CW'(GAP_CYC);
         logic [CW-1:0] remain;
         always_ff @(posedge clk) begin
            if (!rst_n)
               remain <= '0;
            else if (start)
               remain <= LOAD;
            else if (remain != '0)
               remain <= remain - 1'b1;
         end
         assign busy = (remain != '0);
      end
   endgenerate
endmodule

// File: rtl/rw_level_cmp.sv
// Water-mark comparators on the write-buffer occupancy.
module rw_level_cmp #(
   parameter int OCC_W   = 6,
   parameter int HI_MARK = 24,
   parameter int LO_MARK = 8
) (
   input  logic [OCC_W-1:0] level,
   output logic             at_hi,
   output logic             at_lo,
   output logic             nonzero
);
   localparam logic [OCC_W-1:0] HI_V = OCC_W'(HI_MARK);
   localparam logic [OCC_W-1:0] LO_V = OCC_W'(LO_MARK);

   assign at_hi   = (level >= HI_V);
   assign at_lo   = (level <= LO_V);
   assign nonzero = (level != '0);
endmodule

// File: rtl/rw_dir_fsm.sv
// Direction state machine with hysteresis and optional early drain.
module rw_dir_fsm
   import rw_arb_pkg::*;
#(
   parameter bit OPP_DRAIN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rd_pending,
   input  logic at_hi,
   input  logic at_lo,
   output logic dir_wr,
   output logic turn_start
);
   bus_dir_e dir_q, dir_d;
   logic     forced_q, forced_d;
   logic     early_enter, early_exit;

   // Early drain: only used when the option is built in.
   assign early_enter = OPP_DRAIN && !rd_pending && !at_lo;
   assign early_exit  = OPP_DRAIN && rd_pending && !at_hi && !forced_q;

   always_comb begin
      dir_d      = dir_q;
      forced_d   = forced_q;
      turn_start = 1'b0;
      if (!busy) begin
         unique case (dir_q)
            BUS_RD: begin
               if (at_hi) begin
                  dir_d      = BUS_WR;
                  forced_d   = 1'b1;
                  turn_start = 1'b1;
               end else if (early_enter) begin
                  dir_d      = BUS_WR;
                  forced_d   = 1'b0;
                  turn_start = 1'b1;
               end
            end
            BUS_WR: begin
               if (at_lo || early_exit) begin
                  dir_d      = BUS_RD;
                  forced_d   = 1'b0;
                  turn_start = 1'b1;
               end else if (at_hi) begin
                  forced_d = 1'b1;
               end
            end
            default: dir_d = BUS_RD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q    <= BUS_RD;
         forced_q <= 1'b0;
      end else begin
         dir_q    <= dir_d;
         forced_q <= forced_d;
      end
   end

   assign dir_wr = (dir_q == BUS_WR);
endmodule

// File: rtl/rw_bus_arbiter.sv
module rw_bus_arbiter #(
   parameter int OCC_W     = 6,
   parameter int HI_MARK   = 24,
   parameter int LO_MARK   = 8,
   parameter int GAP_CYC   = 3,
   parameter bit OPP_DRAIN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_pending,
   input  logic [OCC_W-1:0] wr_level,
   output logic             bus_is_write,
   output logic             rd_grant,
   output logic             wr_grant,
   output logic             turn_busy
);
   generate
      if (LO_MARK >= HI_MARK) begin : g_bad_marks
         $error("LO_MARK must be below HI_MARK");
      end
      if (HI_MARK > (1 << OCC_W) - 1) begin : g_bad_width
         $error("HI_MARK does not fit in OCC_W bits");
      end
      if (GAP_CYC < 0) begin : g_bad_gap
         $error("GAP_CYC must not be negative");
      end
   endgenerate

   logic at_hi, at_lo, lvl_nz, start, busy, dir_wr;

   rw_level_cmp #(
      .OCC_W  (OCC_W),
      .HI_MARK(HI_MARK),
      .LO_MARK(LO_MARK)
   ) i_cmp (
      .level  (wr_level),
      .at_hi  (at_hi),
      .at_lo  (at_lo),
      .nonzero(lvl_nz)
   );

   rw_dir_fsm #(
      .OPP_DRAIN(OPP_DRAIN)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .rd_pending(rd_pending),
      .at_hi     (at_hi),
      .at_lo     (at_lo),
      .dir_wr    (dir_wr),
      .turn_start(start)
   );

   rw_gap_timer #(
      .GAP_CYC(GAP_CYC)
   ) i_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .busy (busy)
   );

   assign bus_is_write = dir_wr;
   assign turn_busy    = busy;
   assign rd_grant     = !dir_wr && !busy && rd_pending;
   assign wr_grant     = dir_wr && !busy && lvl_nz;
endmodule

// File: rtl/rw_bus_arbiter_chk.sv
module rw_bus_arbiter_chk #(
   parameter int OCC_W     = 6,
   parameter int HI_MARK   = 24,
   parameter int LO_MARK   = 8,
   parameter int GAP_CYC   = 3,
   parameter bit OPP_DRAIN = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_pending,
   input logic [OCC_W-1:0] wr_level,
   input logic             bus_is_write,
   input logic             rd_grant,
   input logic             wr_grant,
   input logic             turn_busy
);
   localparam logic [OCC_W-1:0] HI_V = OCC_W'(HI_MARK);
   localparam logic [OCC_W-1:0] LO_V = OCC_W'(LO_MARK);

   p_grant_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_grant && wr_grant));

   p_quiet_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      turn_busy |-> (!rd_grant && !wr_grant));

   p_hi_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_is_write && !turn_busy && wr_level >= HI_V) |=> bus_is_write);

   p_lo_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_is_write && !turn_busy && wr_level <= LO_V) |=> !bus_is_write);

   p_hold_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_is_write && wr_level > LO_V && (wr_level >= HI_V || !rd_pending))
      |=> bus_is_write);

   p_hold_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_is_write && wr_level < HI_V && rd_pending) |=> !bus_is_write);

   p_wr_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |-> (bus_is_write && wr_level != '0));

   p_frozen_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
      turn_busy |=> $stable(bus_is_write));

   generate
      if (GAP_CYC > 0) begin : g_gap_chk
         localparam int RW = $clog2(GAP_CYC + 2);
         logic [RW-1:0] run;
         always_ff @(posedge clk) begin
            if (!rst_n)
               run <= '0;
            else if (turn_busy)
               run <= (run == RW'(GAP_CYC)) ? run : run + 1'b1;
            else
               run <= '0;
         end

         p_dir_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_is_write != $past(bus_is_write)) |-> turn_busy);

         p_gap_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (turn_busy && run == RW'(GAP_CYC)) |-> 1'b0);
      end
   endgenerate
endmodule

bind rw_bus_arbiter rw_bus_arbiter_chk #(
   .OCC_W    (OCC_W),
   .HI_MARK  (HI_MARK),
   .LO_MARK  (LO_MARK),
   .GAP_CYC  (GAP_CYC),
   .OPP_DRAIN(OPP_DRAIN)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_pending  (rd_pending),
   .wr_level    (wr_level),
   .bus_is_write(bus_is_write),
   .rd_grant    (rd_grant),
   .wr_grant    (wr_grant),
   .turn_busy   (turn_busy)
);

// File: tb/test_rw_bus_arbiter.sv
module test_rw_bus_arbiter;
   localparam int OCC_W = 6;
   localparam int HI = 24;
   localparam int LO = 8;
   localparam int GAP = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rd_pending = 1'b0;
   logic [OCC_W-1:0] wr_level = '0;
   logic             dir_m, rg_m, wg_m, bz_m;
   logic             dir_o, rg_o, wg_o, bz_o;
   int               n_chk = 0;
   int               n_fail = 0;
   bit               done = 1'b0;

   always #5 clk = ~clk;

   rw_bus_arbiter #(.OCC_W(OCC_W), .HI_MARK(HI), .LO_MARK(LO),
                    .GAP_CYC(GAP), .OPP_DRAIN(1'b0)) i_rw_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .rd_pending(rd_pending), .wr_level(wr_level),
      .bus_is_write(dir_m), .rd_grant(rg_m), .wr_grant(wg_m), .turn_busy(bz_m));

   rw_bus_arbiter #(.OCC_W(OCC_W), .HI_MARK(HI), .LO_MARK(LO),
                    .GAP_CYC(GAP), .OPP_DRAIN(1'b1)) i_rw_bus_arbiter_opp (
      .clk(clk), .rst_n(rst_n), .rd_pending(rd_pending), .wr_level(wr_level),
      .bus_is_write(dir_o), .rd_grant(rg_o), .wr_grant(wg_o), .turn_busy(bz_o));

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b (dir,busy,rg,wg)", req, what, act, exp);
      end
   endtask

   // Checks both grants never overlap, then the four-field state.
   task automatic chk_m(string req, string what, logic [3:0] exp);
      chk("R7", {what, " excl"}, {3'b000, rg_m & wg_m}, 4'b0000);
      chk(req, what, {dir_m, bz_m, rg_m, wg_m}, exp);
   endtask

   task automatic chk_o(string req, string what, logic [3:0] exp);
      chk(req, what, {dir_o, bz_o, rg_o, wg_o}, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rd_pending = 1'b0; wr_level = '0;
      tick(2);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk_m("R1", "after reset", 4'b0000);
      chk_o("R1", "opp after reset", 4'b0000);
   endtask

   task automatic t_read_only();
      do_reset();
      rd_pending = 1'b1; wr_level = 6'd23;
      tick();
      chk_m("R2", "read served below high mark", 4'b0010);
      rd_pending = 1'b0; wr_level = 6'd20;
      tick(6);
      chk_m("R2", "idle reads, no early drain", 4'b0000);
   endtask

   task automatic t_drain_cycle();
      do_reset();
      rd_pending = 1'b1; wr_level = 6'd24;
      tick();
      chk_m("R3", "turned to write at high mark", 4'b1100);
      for (int i = 1; i < GAP; i++) begin
         tick();
         chk_m("R5", "write turnaround busy", 4'b1100);
      end
      tick();
      chk_m("R6", "write granted after gap", 4'b1001);
      wr_level = 6'd9;
      tick();
      chk_m("R4", "stays write above low mark", 4'b1001);
      wr_level = 6'd8;
      tick();
      chk_m("R4", "back to read at low mark", 4'b0100);
      for (int i = 1; i < GAP; i++) begin
         tick();
         chk_m("R5", "read turnaround busy", 4'b0100);
      end
      tick();
      chk_m("R5", "read granted after gap", 4'b0010);
   endtask

   task automatic t_frozen_turn();
      do_reset();
      rd_pending = 1'b1; wr_level = 6'd30;
      tick();
      wr_level = 6'd0;
      tick(GAP);
      chk_m("R8", "still write after gap, empty buffer", 4'b1000);
      chk_m("R6", "no write grant when empty", 4'b1000);
      tick();
      chk_m("R8", "decides at first idle edge", 4'b0100);
   endtask

   task automatic t_early_drain();
      do_reset();
      rd_pending = 1'b0; wr_level = 6'd10;
      tick();
      chk_o("R9", "early drain starts", 4'b1100);
      tick(GAP);
      chk_o("R9", "early drain granted", 4'b1001);
      rd_pending = 1'b1; wr_level = 6'd12;
      tick();
      chk_o("R9", "read arrival ends early drain", 4'b0100);
   endtask

   task automatic t_forced_keep();
      do_reset();
      rd_pending = 1'b0; wr_level = 6'd10;
      tick();
      wr_level = 6'd25;
      tick(GAP);
      tick();
      chk_o("R10", "promoted at high mark", 4'b1001);
      rd_pending = 1'b1; wr_level = 6'd15;
      tick();
      chk_o("R10", "forced drain ignores read", 4'b1001);
      wr_level = 6'd8;
      tick();
      chk_o("R10", "forced drain ends at low mark", 4'b0100);
   endtask

   initial begin
      t_reset();
      t_read_only();
      t_drain_cycle();
      t_frozen_turn();
      t_early_drain();
      t_forced_keep();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule